// File: doc/BRIEF.md
# Conversion Data-Ready Handshake Controller

This block sits between a converter's result path and its serial host port and drives an active-low ready flag. Conversion results arrive as single-cycle strobes carrying a 16-bit word and are held in a staging register. At a fixed update instant, once every `PERIOD` master clocks, the newest staged word is copied into the host-visible output register and the flag drops low. The host reads the word through the serial interface, which reports a finished full-word read with a one-cycle pulse, and the flag then returns high.

To keep the host away from the output register while it is being overwritten, the flag is forced high for the last `BLANK` master clocks of every period, whether or not a read has happened. A read-complete pulse that lands in that window has no effect. The flag is also used to mark the end of a calibration: a calibration-done pulse pulls it low and restarts the update period from its first position.

Top module: `drdy_handshake_ctrl`

## Requirements
- R1: While reset is low and after it is released, the flag `rdy_n` is high and `data_word` is zero; the period position starts at 0.
- R2: The period position counts 0 to `PERIOD-1` and wraps; on the clock edge that ends position `PERIOD-1`, a staged word (one strobed since the last update) is copied to `data_word` and `rdy_n` goes low, both visible at position 0.
- R3: A `rd_done` pulse while `rdy_n` is low, outside the blanking window, sets `rdy_n` high on the next edge and leaves `data_word` unchanged.
- R4: A `rd_done` pulse while `rdy_n` is already high (a repeated read) leaves `rdy_n` high and `data_word` unchanged.
- R5: `rdy_n` is high at every position from `PERIOD-BLANK` to `PERIOD-1`, even when no read has taken place; at position `PERIOD-BLANK-1` it still holds its earlier value.
- R6: A `rd_done` pulse during the blanking window is ignored: `rdy_n` stays high and `data_word` stays unchanged until the update, where a staged word still drives `rdy_n` low.
- R7: `data_word` changes only on the update edge, never on a strobe, a read or during blanking.
- R8: An update with no word strobed since the previous update leaves `data_word` unchanged and `rdy_n` high.
- R9: When several words are strobed within one period, the last one is the word loaded at the update.
- R10: A `cal_done` pulse drives `rdy_n` low on the next edge without changing `data_word`, and resets the period position to 0, so blanking and the next update are timed from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | One-cycle strobe: new conversion result on `conv_word` |
| conv_word | input | 16 | Conversion result word |
| rd_done | input | 1 | One-cycle pulse: host finished reading a full word |
| cal_done | input | 1 | One-cycle pulse: calibration finished |
| data_word | output | 16 | Host-visible output word |
| rdy_n | output | 1 | Active-low data-ready flag |

## Verification
The bench aligns itself to the period with a calibration pulse and then probes the positions on either side of the blanking edge: a window starting one cycle late or early would show the flag at the wrong level at `PERIOD-BLANK-1` or `PERIOD-BLANK`. A read pulse placed inside the window catches a design that lets a late read reopen the flag or disturb the word, and a period with no new strobe catches one that drops the flag at every update regardless. A calibration pulse mid-period, with a word staged, exposes a design that keeps its old period phase (blanking would begin far too early) or that loads the staged word on the calibration edge.

// File: rtl/drdy_pkg.sv
package drdy_pkg;

    // Flag controller states; only FLG_AVAIL drives the ready flag low.
    typedef enum logic [1:0] {
        FLG_WAIT  = 2'd0,
        FLG_AVAIL = 2'd1,
        FLG_BLANK = 2'd2
    } flag_state_t;

endpackage

// File: rtl/drdy_period_timer.sv
module drdy_period_timer #(
    parameter int PERIOD = 2000,
    parameter int BLANK  = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic at_update,
    output logic blank_next
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST_POS    = CW'(PERIOD - 1);
    localparam logic [CW-1:0] BLANK_START = CW'(PERIOD - BLANK);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        at_update = (tmr_q.cnt == LAST_POS);
        if (restart || at_update) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        blank_next = (tmr_d.cnt >= BLANK_START);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST_POS); // R2

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tmr_q.cnt == '0)); // R10

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        at_update |=> (tmr_q.cnt == '0)); // R2

endmodule

// File: rtl/drdy_stage.sv
module drdy_stage #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [WORD_W-1:0] conv_word,
    input  logic              take,
    output logic              pending,
    output logic [WORD_W-1:0] staged_word
);
    typedef struct packed {
        logic              pend;
        logic [WORD_W-1:0] word;
    } stg_t;

    stg_t stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        if (conv_valid) begin
            stg_d.word = conv_word;
            stg_d.pend = 1'b1;
        end else if (take) begin
            stg_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign pending     = stg_q.pend;
    assign staged_word = stg_q.word;

    AST_STROBE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> pending); // R9

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !conv_valid) |=> !pending); // R8

endmodule

// File: rtl/drdy_flag_ctrl.sv
module drdy_flag_ctrl
    import drdy_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_update,
    input  logic              blank_next,
    input  logic              cal_done,
    input  logic              rd_done,
    input  logic              pending,
    input  logic [WORD_W-1:0] staged_word,
    output logic              take,
    output logic [WORD_W-1:0] data_word,
    output logic              rdy_n
);
    typedef struct packed {
        flag_state_t       st;
        logic [WORD_W-1:0] data;
    } flg_t;

    flg_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        take  = at_update && pending;
        if (take) begin
            flg_d.data = staged_word;
        end
        if (cal_done || take) begin
            flg_d.st = FLG_AVAIL;
        end else if (at_update) begin
            flg_d.st = FLG_WAIT;
        end else if (blank_next) begin
            flg_d.st = FLG_BLANK;
        end else if (rd_done && flg_q.st == FLG_AVAIL) begin
            flg_d.st = FLG_WAIT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q.st   <= FLG_WAIT;
            flg_q.data <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign data_word = flg_q.data;
    assign rdy_n     = (flg_q.st != FLG_AVAIL);

    AST_WORD_ONLY_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_word != $past(data_word)) |-> $past(at_update)); // R7

    AST_READ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !at_update && !cal_done) |=> rdy_n); // R3

    AST_CAL_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !rdy_n); // R10

    AST_READ_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !at_update) |=> $stable(data_word)); // R4

endmodule

// File: rtl/drdy_handshake_ctrl.sv
module drdy_handshake_ctrl #(
    parameter int WORD_W = 16,
    parameter int PERIOD = 2000,
    parameter int BLANK  = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [WORD_W-1:0] conv_word,
    input  logic              rd_done,
    input  logic              cal_done,
    output logic [WORD_W-1:0] data_word,
    output logic              rdy_n
);
    logic              at_update;
    logic              blank_next;
    logic              take;
    logic              pending;
    logic [WORD_W-1:0] staged_word;

    drdy_period_timer #(
        .PERIOD (PERIOD),
        .BLANK  (BLANK)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cal_done),
        .at_update  (at_update),
        .blank_next (blank_next)
    );

    drdy_stage #(
        .WORD_W (WORD_W)
    ) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_valid  (conv_valid),
        .conv_word   (conv_word),
        .take        (take),
        .pending     (pending),
        .staged_word (staged_word)
    );

    drdy_flag_ctrl #(
        .WORD_W (WORD_W)
    ) u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .at_update   (at_update),
        .blank_next  (blank_next),
        .cal_done    (cal_done),
        .rd_done     (rd_done),
        .pending     (pending),
        .staged_word (staged_word),
        .take        (take),
        .data_word   (data_word),
        .rdy_n       (rdy_n)
    );

    AST_BLANK_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_next && !cal_done) |=> rdy_n); // R5

    AST_BLANK_IGNORES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_next && rd_done && !cal_done) |=> $stable(data_word)); // R6

endmodule

// File: tb/drdy_handshake_ctrl_test.sv
module drdy_handshake_ctrl_test;
    localparam int P = 2000;
    localparam int B = 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_word = '0;
    logic        rd_done = 1'b0;
    logic        cal_done = 1'b0;
    logic [15:0] data_word;
    logic        rdy_n;

    int checks = 0;
    int fails  = 0;
    int ph     = 0;

    always #5 clk = ~clk;

    drdy_handshake_ctrl #(.WORD_W(16), .PERIOD(P), .BLANK(B)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_valid (conv_valid),
        .conv_word  (conv_word),
        .rd_done    (rd_done),
        .cal_done   (cal_done),
        .data_word  (data_word),
        .rdy_n      (rdy_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at pos %0d: actual %h expected %h", req, ph, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        ph = (ph + 1) % P;
    endtask

    task automatic goto_pos(input int k);
        while (ph != k) step();
    endtask

    task automatic pulse_read();
        rd_done = 1'b1; step(); rd_done = 1'b0;
    endtask

    task automatic pulse_conv(input logic [15:0] w);
        conv_word = w; conv_valid = 1'b1; step(); conv_valid = 1'b0;
    endtask

    task automatic pulse_cal();
        cal_done = 1'b1; step(); cal_done = 1'b0;
        ph = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 flag in reset", rdy_n, 1'b1);
        chk("R1 word in reset", data_word, 16'h0000);
        rst_n = 1'b1;
        ph = 0;
        step(); step();
        chk("R1 flag after release", rdy_n, 1'b1);
        chk("R1 word after release", data_word, 16'h0000);
    endtask

    task automatic t_cal_and_reads();
        step();
        pulse_cal();
        chk("R10 cal lowers flag", rdy_n, 1'b0);
        chk("R10 cal keeps word", data_word, 16'h0000);
        goto_pos(10);
        pulse_read();
        chk("R3 read raises flag", rdy_n, 1'b1);
        chk("R3 read keeps word", data_word, 16'h0000);
        goto_pos(20);
        pulse_read();
        chk("R4 reread flag", rdy_n, 1'b1);
        chk("R4 reread word", data_word, 16'h0000);
    endtask

    task automatic t_first_update();
        goto_pos(100);
        pulse_conv(16'h1234);
        chk("R7 strobe not visible", data_word, 16'h0000);
        goto_pos(P - 1);
        chk("R7 word before update", data_word, 16'h0000);
        chk("R5 flag high before update", rdy_n, 1'b1);
        goto_pos(0);
        chk("R2 word loaded", data_word, 16'h1234);
        chk("R2 flag low at update", rdy_n, 1'b0);
    endtask

    task automatic t_blanking();
        goto_pos(200);
        pulse_conv(16'hBEEF);
        goto_pos(P - B - 1);
        chk("R5 flag before window", rdy_n, 1'b0);
        step();
        chk("R5 flag at window start", rdy_n, 1'b1);
        goto_pos(1600);
        pulse_read();
        chk("R6 read in window flag", rdy_n, 1'b1);
        chk("R6 read in window word", data_word, 16'h1234);
        goto_pos(P - 1);
        chk("R7 word held in window", data_word, 16'h1234);
        goto_pos(0);
        chk("R6 update after window word", data_word, 16'hBEEF);
        chk("R6 update after window flag", rdy_n, 1'b0);
    endtask

    task automatic t_no_new_word();
        goto_pos(50);
        pulse_read();
        chk("R3 read raises flag again", rdy_n, 1'b1);
        goto_pos(0);
        chk("R8 empty update flag", rdy_n, 1'b1);
        chk("R8 empty update word", data_word, 16'hBEEF);
    endtask

    task automatic t_last_wins();
        goto_pos(300);
        pulse_conv(16'h1111);
        goto_pos(400);
        pulse_conv(16'h2222);
        goto_pos(0);
        chk("R9 last strobe loaded", data_word, 16'h2222);
        chk("R9 flag low", rdy_n, 1'b0);
    endtask

    task automatic t_cal_restart();
        goto_pos(50);
        pulse_read();
        goto_pos(100);
        pulse_conv(16'h3333);
        goto_pos(700);
        pulse_cal();
        chk("R10 cal mid period flag", rdy_n, 1'b0);
        chk("R10 cal does not load", data_word, 16'h2222);
        goto_pos(800);
        chk("R10 old phase window absent", rdy_n, 1'b0);
        goto_pos(P - B - 1);
        chk("R10 flag before new window", rdy_n, 1'b0);
        step();
        chk("R10 new window start", rdy_n, 1'b1);
        goto_pos(0);
        chk("R10 update on new phase word", data_word, 16'h3333);
        chk("R10 update on new phase flag", rdy_n, 1'b0);
    endtask

    initial begin
        t_reset();
        t_cal_and_reads();
        t_first_update();
        t_blanking();
        t_no_new_word();
        t_last_wins();
        t_cal_restart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired at pos %0d: actual %h expected %h", ph, 1'b1, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule